// File: doc/BRIEF.md
# CORDIC Givens Rotation Unit

This block performs the two-row rotation at the heart of a Givens-style triangularisation. It uses only adders and shifts. A *leader* pair (x, y) taken from two adjacent matrix rows passes through a chain of micro-rotation stages that work in vectoring mode. Each stage picks the rotation direction that moves y toward zero, and the leader leaves the unit as (±magnitude, ≈0). Every stage records the direction it chose for that leader.

*Follower* pairs are the other columns of the same two rows. They enter after their leader and pass through the same stages. Each stage applies the stored direction instead of choosing a new one, so every follower turns by exactly the leader's angle. No angle is ever formed. A fixed shift-and-add network removes the CORDIC gain, and the result is rounded and clipped to the operand format.

Leaders and followers share one input port and are told apart by a flag. Any sequence of leaders and followers, one per cycle, is accepted. A new leader replaces the stored directions for all pairs that come after it.

Top module: `cordic_givens`

## Requirements
- R1: While reset is high and on the first cycle after it, out_valid is 0 and out_x and out_y are 0.
- R2: Every accepted input (in_valid high) produces exactly one output. The output appears STAGES+2 cycles later (10 with defaults), in input order, with out_lead equal to the in_lead given with that input.
- R3: For a leader, out_y is within ±(1.2% of the pair magnitude + 4 LSB) of zero. out_x is negative exactly when in_x is negative; in_x = 0 counts as positive.
- R4: A follower (in_lead = 0) is rotated by −atan(ly/lx), where (lx, ly) is the most recent earlier leader. When lx = 0 the angle is +90° if ly ≥ 0 and −90° otherwise. The tolerance is 1.2% of the pair magnitude + 4 LSB.
- R5: A leader replaces the stored directions only for pairs that enter after it. This holds even on back-to-back cycles. Followers that entered before it keep the earlier leader's rotation.
- R6: The gain is compensated. A leader's |out_x| equals sqrt(x²+y²) within the R3 tolerance.
- R7: Results are two's complement, DW bits with FW fractional bits (Q4.8 by default), rounded to nearest. A result beyond the format clips to +2^(DW−1)−1 or −2^(DW−1) instead of wrapping.
- R8: Reset clears every stored direction to the counter-clockwise choice. A follower that enters before any leader is therefore rotated counter-clockwise by the sum of atan(2^−i) for i = 0..STAGES−1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pair present this cycle |
| in_lead | input | 1 | 1: leader (choose and store directions); 0: follower (replay) |
| in_x | input | DW | First-row term, signed fixed point |
| in_y | input | DW | Second-row term, signed fixed point |
| out_valid | output | 1 | Output pair present |
| out_lead | output | 1 | Leader/follower flag of the output pair |
| out_x | output | DW | Rotated first-row term |
| out_y | output | DW | Rotated second-row term |

## Verification
The hardest case to reach is a change of leader while followers of the old leader are still in the pipeline. The stored directions then belong to two different leaders at different depths of the stage chain. The stimulus sends a leader, one follower, and on the very next cycle a second leader with more followers. Each follower must match the rotation angle of the leader that came before it. Followers sent straight after reset show the cleared direction state. A large leader and a corner follower push the compensated result past full scale so that the clipping is exercised.

// File: rtl/cgr_pkg.sv
package cgr_pkg;
  // Direction chosen by a micro-rotation stage.
  typedef enum logic {
    ROT_CCW = 1'b0,  // x -= y>>s, y += x>>s
    ROT_CW  = 1'b1   // x += y>>s, y -= x>>s
  } rot_dir_e;

  // Inverse gain 0.60725 as signed power-of-two terms:
  // 2^-1 + 2^-3 - 2^-6 - 2^-9 - 2^-12
  localparam int GAIN_TERMS = 5;
  localparam int unsigned GAIN_SH [GAIN_TERMS] = '{1, 3, 6, 9, 12};
  localparam bit GAIN_NEG [GAIN_TERMS] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1};
endpackage

// File: rtl/cgr_stage.sv
module cgr_stage
  import cgr_pkg::*;
#(
  parameter int W     = 18,
  parameter int SHIFT = 0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic                in_lead,
  input  logic signed [W-1:0] in_x,
  input  logic signed [W-1:0] in_y,
  output logic                out_valid,
  output logic                out_lead,
  output logic signed [W-1:0] out_x,
  output logic signed [W-1:0] out_y
);
  rot_dir_e dir_q;
  rot_dir_e dir_now;
  logic signed [W-1:0] xs, ys, nx, ny;

  always_comb begin
    if (in_lead) dir_now = (in_x[W-1] == in_y[W-1]) ? ROT_CW : ROT_CCW;
    else         dir_now = dir_q;
    xs = in_x >>> SHIFT;
    ys = in_y >>> SHIFT;
    if (dir_now == ROT_CW) begin
      nx = in_x + ys;
      ny = in_y - xs;
    end else begin
      nx = in_x - ys;
      ny = in_y + xs;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_lead  <= 1'b0;
      out_x     <= '0;
      out_y     <= '0;
      dir_q     <= ROT_CCW;
    end else begin
      out_valid <= in_valid;
      out_lead  <= in_lead;
      out_x     <= nx;
      out_y     <= ny;
      if (in_valid && in_lead) dir_q <= dir_now;
    end
  end
endmodule

// File: rtl/cgr_gain.sv
module cgr_gain
  import cgr_pkg::*;
#(
  parameter int W     = 18,
  parameter int DW    = 12,
  parameter int GUARD = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic                 in_lead,
  input  logic signed [W-1:0]  in_x,
  input  logic signed [W-1:0]  in_y,
  output logic                 out_valid,
  output logic                 out_lead,
  output logic signed [DW-1:0] out_x,
  output logic signed [DW-1:0] out_y
);
  localparam logic signed [W:0] RND  = (W+1)'(2**(GUARD-1));
  localparam logic signed [W:0] MAXV = (W+1)'(2**(DW-1)-1);
  localparam logic signed [W:0] MINV = (W+1)'(-(2**(DW-1)));

  function automatic logic signed [W-1:0] scale(input logic signed [W-1:0] v);
    logic signed [W-1:0] acc;
    acc = '0;
    for (int k = 0; k < GAIN_TERMS; k++) begin
      if (GAIN_NEG[k]) acc = acc - (v >>> GAIN_SH[k]);
      else             acc = acc + (v >>> GAIN_SH[k]);
    end
    return acc;
  endfunction

  function automatic logic signed [DW-1:0] sat_round(input logic signed [W-1:0] v);
    logic signed [W:0] t;
    t = {v[W-1], v};
    t = t + RND;
    t = t >>> GUARD;
    if (t > MAXV) t = MAXV;
    else if (t < MINV) t = MINV;
    return t[DW-1:0];
  endfunction

  logic                c_valid, c_lead;
  logic signed [W-1:0] c_x, c_y;

  always_ff @(posedge clk) begin
    if (rst) begin
      c_valid   <= 1'b0;
      c_lead    <= 1'b0;
      c_x       <= '0;
      c_y       <= '0;
      out_valid <= 1'b0;
      out_lead  <= 1'b0;
      out_x     <= '0;
      out_y     <= '0;
    end else begin
      c_valid   <= in_valid;
      c_lead    <= in_lead;
      c_x       <= scale(in_x);
      c_y       <= scale(in_y);
      out_valid <= c_valid;
      out_lead  <= c_lead;
      out_x     <= sat_round(c_x);
      out_y     <= sat_round(c_y);
    end
  end
endmodule

// File: rtl/cordic_givens.sv
module cordic_givens #(
  parameter int DW    = 12,
  parameter int FW    = 8,
  parameter int GUARD = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic                 in_lead,
  input  logic signed [DW-1:0] in_x,
  input  logic signed [DW-1:0] in_y,
  output logic                 out_valid,
  output logic                 out_lead,
  output logic signed [DW-1:0] out_x,
  output logic signed [DW-1:0] out_y
);
  localparam int STAGES = FW;
  localparam int HEAD   = 2;               // headroom for gain and vector growth
  localparam int W      = DW + HEAD + GUARD;

  logic                pv [STAGES+1];
  logic                pl [STAGES+1];
  logic signed [W-1:0] px [STAGES+1];
  logic signed [W-1:0] py [STAGES+1];

  assign pv[0] = in_valid;
  assign pl[0] = in_lead;
  assign px[0] = {{HEAD{in_x[DW-1]}}, in_x, {GUARD{1'b0}}};
  assign py[0] = {{HEAD{in_y[DW-1]}}, in_y, {GUARD{1'b0}}};

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    cgr_stage #(.W(W), .SHIFT(i)) u_stage (
      .clk      (clk),
      .rst      (rst),
      .in_valid (pv[i]),
      .in_lead  (pl[i]),
      .in_x     (px[i]),
      .in_y     (py[i]),
      .out_valid(pv[i+1]),
      .out_lead (pl[i+1]),
      .out_x    (px[i+1]),
      .out_y    (py[i+1])
    );
  end

  cgr_gain #(.W(W), .DW(DW), .GUARD(GUARD)) u_gain (
    .clk      (clk),
    .rst      (rst),
    .in_valid (pv[STAGES]),
    .in_lead  (pl[STAGES]),
    .in_x     (px[STAGES]),
    .in_y     (py[STAGES]),
    .out_valid(out_valid),
    .out_lead (out_lead),
    .out_x    (out_x),
    .out_y    (out_y)
  );
endmodule

// File: rtl/cordic_givens_chk.sv
module cordic_givens_chk #(
  parameter int DW  = 12,
  parameter int LAT = 10
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic                 in_lead,
  input logic signed [DW-1:0] in_x,
  input logic                 out_valid,
  input logic                 out_lead,
  input logic signed [DW-1:0] out_x,
  input logic signed [DW-1:0] out_y
);
  localparam logic signed [DW-1:0] YB = DW'(2**(DW-1) / 32);

  logic [LAT-1:0] vs, ls, ss;

  always_ff @(posedge clk) begin
    if (rst) begin
      vs <= '0;
      ls <= '0;
      ss <= '0;
    end else begin
      vs <= {vs[LAT-2:0], in_valid};
      ls <= {ls[LAT-2:0], in_lead};
      ss <= {ss[LAT-2:0], in_x[DW-1]};
    end
  end

  // R1
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!out_valid && out_x == '0 && out_y == '0));

  // R2
  a_r2_fixed_latency: assert property (@(posedge clk) disable iff (rst)
    out_valid == vs[LAT-1]);

  // R2
  a_r2_lead_tag: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_lead == ls[LAT-1]));

  // R3
  a_r3_leader_sign: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_lead) |-> (out_x[DW-1] == ss[LAT-1]));

  // R3
  a_r3_leader_y_small: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_lead) |-> (out_y <= YB && out_y >= -YB));
endmodule

bind cordic_givens cordic_givens_chk #(.DW(DW), .LAT(FW + 2)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_lead  (in_lead),
  .in_x     (in_x),
  .out_valid(out_valid),
  .out_lead (out_lead),
  .out_x    (out_x),
  .out_y    (out_y)
);

// File: tb/cordic_givens_tb.sv
module cordic_givens_tb;
  localparam int DW  = 12;
  localparam int FW  = 8;
  localparam int LAT = FW + 2;
  localparam real MAXR = 2.0**(DW-1) - 1.0;
  localparam real MINR = -(2.0**(DW-1));
  localparam real PI   = 3.14159265358979;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_lead = 1'b0;
  logic signed [DW-1:0] in_x = '0, in_y = '0;
  logic out_valid, out_lead;
  logic signed [DW-1:0] out_x, out_y;

  always #2.5 clk = ~clk;

  cordic_givens #(.DW(DW), .FW(FW), .GUARD(4)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_lead(in_lead),
    .in_x(in_x), .in_y(in_y), .out_valid(out_valid), .out_lead(out_lead),
    .out_x(out_x), .out_y(out_y)
  );

  int cyc = 0;
  int nchk = 0, nbad = 0;
  bit done = 0;
  real phi;

  real   q_ex[$], q_ey[$], q_tol[$];
  int    q_cyc[$];
  bit    q_lead[$], q_neg[$];
  string q_req[$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic real clipr(input real v);
    if (v > MAXR) return MAXR;
    if (v < MINR) return MINR;
    return v;
  endfunction

  task automatic check_val(input string req, input string what, input int act,
                           input real exp, input real tol);
    real lo, hi;
    lo = clipr(exp - tol);
    hi = clipr(exp + tol);
    nchk++;
    if (real'(act) < lo || real'(act) > hi) begin
      nbad++;
      $display("FAIL %s %s: actual=%0d expected=%0.2f (+-%0.2f)", req, what, act, exp, tol);
    end
  endtask

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Driver: call at a negedge; drives one pair and returns at the next negedge.
  task automatic send(input bit lead, input int x, input int y, input string req);
    real ex, ey, mag;
    mag = $sqrt(real'(x*x + y*y));
    if (lead) begin
      if (x == 0) phi = (y >= 0) ? PI/2.0 : -PI/2.0;
      else        phi = $atan(real'(y) / real'(x));
      ex = (x < 0) ? -mag : mag;
      ey = 0.0;
    end else begin
      ex =  $cos(phi) * x + $sin(phi) * y;
      ey = -$sin(phi) * x + $cos(phi) * y;
    end
    q_ex.push_back(ex);
    q_ey.push_back(ey);
    q_tol.push_back(0.012 * mag + 4.0);
    q_cyc.push_back(cyc);
    q_lead.push_back(lead);
    q_neg.push_back(x < 0);
    q_req.push_back(req);
    in_valid = 1'b1;
    in_lead  = lead;
    in_x     = x[DW-1:0];
    in_y     = y[DW-1:0];
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && out_valid) begin
        if (q_ex.size() == 0) begin
          nchk++; nbad++;
          $display("FAIL R2 unexpected output: actual=valid expected=idle");
        end else begin
          real ex, ey, tol;
          int  c0;
          bit  ld, ng;
          string rq;
          ex = q_ex.pop_front(); ey = q_ey.pop_front(); tol = q_tol.pop_front();
          c0 = q_cyc.pop_front(); ld = q_lead.pop_front(); ng = q_neg.pop_front();
          rq = q_req.pop_front();
          check_eq("R2", "latency", cyc - c0, LAT);
          check_eq("R2", "lead flag", int'(out_lead), int'(ld));
          if (ld) begin
            check_val((rq == "R3") ? "R6" : rq, "leader x", int'(out_x), ex, tol);
            check_val("R3", "leader y", int'(out_y), ey, tol);
            check_eq("R3", "leader sign", int'(out_x[DW-1]), int'(ng));
          end else begin
            check_val(rq, "follower x", int'(out_x), ex, tol);
            check_val(rq, "follower y", int'(out_y), ey, tol);
          end
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++; nbad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    real acc;
    acc = 0.0;
    for (int i = 0; i < FW; i++) acc += $atan(2.0**(-i));
    phi = -acc;  // R8: cleared directions rotate counter-clockwise by acc

    repeat (4) @(negedge clk);
    // R1: reset state
    check_eq("R1", "out_valid in reset", int'(out_valid), 0);
    check_eq("R1", "out_x in reset", int'(out_x), 0);
    check_eq("R1", "out_y in reset", int'(out_y), 0);
    rst = 1'b0;
    @(negedge clk);
    check_eq("R1", "out_valid after reset", int'(out_valid), 0);

    // R8: followers before any leader
    send(0, 500, 200, "R8");
    send(0, -300, 600, "R8");

    // R3 / R4 / R6: leaders in every quadrant, each with followers
    send(1, 1000, 300, "R3");
    send(0, 400, -700, "R4");
    send(0, -900, 100, "R4");
    send(1, -700, 400, "R3");
    send(0, 600, 600, "R4");
    repeat (3) @(negedge clk);
    send(0, -200, -1000, "R4");
    send(1, 500, -900, "R3");
    send(0, 1200, 50, "R4");
    send(1, -300, -1200, "R3");
    send(0, 250, -800, "R4");
    send(1, 0, 800, "R3");
    send(0, 700, 300, "R4");
    send(1, 1500, 0, "R3");
    send(0, -400, 900, "R4");

    // R5: leader change with old followers still in flight
    send(1, 800, 800, "R3");
    send(0, 1000, -200, "R5");
    send(1, -600, 900, "R3");
    send(0, 1000, -200, "R5");
    send(0, -500, -500, "R5");

    // R7: clipping of leader and follower results
    send(1, 2047, 2047, "R7");
    send(1, -2048, -2048, "R7");
    send(1, 1000, 1000, "R3");
    send(0, -2048, -2048, "R7");
    send(0, 2047, 2047, "R7");

    repeat (LAT + 6) @(negedge clk);
    check_eq("R2", "outstanding outputs", q_ex.size(), 0);

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end
endmodule